// File: doc/BRIEF.md
# Cartridge Bank Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and the ROM and RAM chips of a plug-in cartridge. Any CPU write that lands in the lower half of the address space, 0x0000 to 0x7FFF, never reaches the ROM. Instead it is decoded as a write to one of four control registers. The block holds the register contents and combines them with the live CPU address. From that it forms the physical ROM address, the physical RAM address and a chip-select for the external RAM.

The CPU address space has two ROM windows. The lower window, 0x0000 to 0x3FFF, always shows bank 0. The upper window, 0x4000 to 0x7FFF, shows the selected bank. The selected bank number is seven bits wide. Its low five bits have a register of their own. Its upper two bits share a two-bit register with the RAM bank number, and a mode bit decides which of the two uses that register serves. Whenever the mode is written, the use that was given up is cleared.

The ROM size is a static parameter given as a power-of-two bank count. A bank number larger than the ROM wraps onto the banks that exist. The mapper has no data path of its own and no back-pressure. The write strobe is a plain one-cycle qualifier that takes effect at the next rising clock edge. The address outputs are combinational functions of the current address and the register state.

Top module: `bank_mapper`

## Requirements
- R1: After reset the selected ROM bank is 1, the RAM bank is 0, the mode is 0 and external RAM is disabled.
- R2: A write to 0x0000–0x1FFF enables external RAM when the data is 0x0A and disables it when the data is 0x00. Any other data value leaves the enable unchanged.
- R3: A write to 0x2000–0x3FFF loads data bits [4:0] into ROM bank bits [4:0]. A value of zero is stored as 1. ROM bank bits [6:5] are kept.
- R4: A write to 0x4000–0x5FFF uses only data bits [1:0]. In mode 0 they become ROM bank bits [6:5] and the RAM bank is not touched. In mode 1 they become the RAM bank and the ROM bank is not touched. In mode 0 the RAM bank is always 0.
- R5: A write to 0x6000–0x7FFF sets the mode from data bit 0. Writing 1 clears ROM bank bits [6:5]. Writing 0 forces the RAM bank to 0.
- R6: The ROM bank driven out is the selected bank ANDed with (ROM_BANKS − 1). With ROM_BANKS = 64, bank bit 6 is dropped.
- R7: For addresses 0x0000–0x3FFF, rom_addr is {0, addr[13:0]}. For 0x4000–0x7FFF, rom_addr is {bank, addr[13:0]}, with the bank in the top ROM_BW bits.
- R8: ram_cs is high only when RAM is enabled and the address is in 0xA000–0xBFFF. ram_addr is {ram_bank, addr[12:0]}, with the RAM bank in the top two bits.
- R9: A write strobe with address bit 15 set changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register writes take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| rom_addr | output | ROM_BW+14 | Physical ROM address: bank in the top bits, window offset below |
| ram_addr | output | 15 | Physical RAM address: RAM bank in the top 2 bits, offset below |
| ram_cs | output | 1 | External RAM chip-select |

## Verification
The hardest state to reach from the ports is the interplay of the shared two-bit register with the mode bit. The interesting case has ROM bank bit 6 set and wrapped away by the size mask while bit 5 stays visible. It then needs a switch to mode 1 that must clear both bits. After that, a RAM-bank write must leave the ROM bank alone, and a return to mode 0 must discard the RAM bank. The stimulus builds this state with a chain of register writes in one fixed order. It samples the ROM bank through the upper window and the RAM bank through the RAM window between the writes. Writes with address bit 15 set, whose data would otherwise disable RAM or change the bank, are checked the same way.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  localparam int BANK_LO_W   = 5;
  localparam int BANK_HI_W   = 2;
  localparam int BANK_W      = BANK_LO_W + BANK_HI_W;
  localparam int ROM_OFS_W   = 14;
  localparam int RAM_OFS_W   = 13;
  localparam int NUM_REGIONS = 4;

  localparam logic [7:0] RAM_ON_KEY  = 8'h0A;
  localparam logic [7:0] RAM_OFF_KEY = 8'h00;

  localparam logic [2:0] RAM_WINDOW = 3'b101;

  typedef enum logic [1:0] {
    RGN_RAM_GATE = 2'd0,
    RGN_BANK_LO  = 2'd1,
    RGN_SHARED   = 2'd2,
    RGN_MODE     = 2'd3
  } region_e;

endpackage

// File: rtl/bank_mapper_decode.sv
module bank_mapper_decode
  import bank_mapper_pkg::*;
(
  input  logic [2:0]             addr_top,
  input  logic                   cpu_we,
  output logic [NUM_REGIONS-1:0] rgn_wr
);

  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
      assign rgn_wr[g] = cpu_we && !addr_top[2] && (addr_top[1:0] == 2'(g));
    end
  endgenerate

endmodule

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
  import bank_mapper_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_REGIONS-1:0] rgn_wr,
  input  logic [7:0]             wdata,
  output logic                   ram_en,
  output logic                   mode,
  output logic [BANK_LO_W-1:0]   bank_lo,
  output logic [BANK_HI_W-1:0]   bank_hi,
  output logic [BANK_HI_W-1:0]   ram_bank
);

  logic [BANK_LO_W-1:0] lo_next;
  assign lo_next = (wdata[BANK_LO_W-1:0] == '0) ? BANK_LO_W'(1) : wdata[BANK_LO_W-1:0];

  // RAM gate register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ram_en <= 1'b0;
    else if (rgn_wr[RGN_RAM_GATE]) begin
      if (wdata == RAM_ON_KEY)
        ram_en <= 1'b1;
      else if (wdata == RAM_OFF_KEY)
        ram_en <= 1'b0;
    end
  end

  // low bank bits, zero mapped to one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bank_lo <= BANK_LO_W'(1);
    else if (rgn_wr[RGN_BANK_LO])
      bank_lo <= lo_next;
  end

  // mode bit and the two users of the shared field
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= 1'b0;
      bank_hi  <= '0;
      ram_bank <= '0;
    end else if (rgn_wr[RGN_MODE]) begin
      mode <= wdata[0];
      if (wdata[0])
        bank_hi <= '0;
      else
        ram_bank <= '0;
    end else if (rgn_wr[RGN_SHARED]) begin
      if (mode)
        ram_bank <= wdata[BANK_HI_W-1:0];
      else
        bank_hi <= wdata[BANK_HI_W-1:0];
    end
  end

endmodule

// File: rtl/bank_mapper_xlate.sv
module bank_mapper_xlate
  import bank_mapper_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  localparam int ROM_BW = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1
) (
  input  logic [15:0]                 cpu_addr,
  input  logic [BANK_LO_W-1:0]        bank_lo,
  input  logic [BANK_HI_W-1:0]        bank_hi,
  input  logic [BANK_HI_W-1:0]        ram_bank,
  input  logic                        ram_en,
  output logic [ROM_BW+ROM_OFS_W-1:0] rom_addr,
  output logic [BANK_HI_W+RAM_OFS_W-1:0] ram_addr,
  output logic                        ram_cs
);

  localparam logic [BANK_W-1:0] ROM_MASK = BANK_W'(ROM_BANKS - 1);

  logic [BANK_W-1:0] bank_full;
  logic [ROM_BW-1:0] rom_bank;

  always_comb begin
    bank_full = {bank_hi, bank_lo} & ROM_MASK;
    rom_bank  = ROM_BW'(bank_full);
    if (cpu_addr[14])
      rom_addr = {rom_bank, cpu_addr[ROM_OFS_W-1:0]};
    else
      rom_addr = {ROM_BW'(0), cpu_addr[ROM_OFS_W-1:0]};
  end

  assign ram_addr = {ram_bank, cpu_addr[RAM_OFS_W-1:0]};
  assign ram_cs   = ram_en && (cpu_addr[15:13] == RAM_WINDOW);

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  localparam int ROM_BW = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [15:0]                    cpu_addr,
  input  logic [7:0]                     cpu_wdata,
  input  logic                           cpu_we,
  output logic [ROM_BW+ROM_OFS_W-1:0]    rom_addr,
  output logic [BANK_HI_W+RAM_OFS_W-1:0] ram_addr,
  output logic                           ram_cs
);

  logic [NUM_REGIONS-1:0] rgn_wr;
  logic                   ram_en;
  logic                   mode;
  logic [BANK_LO_W-1:0]   bank_lo;
  logic [BANK_HI_W-1:0]   bank_hi;
  logic [BANK_HI_W-1:0]   ram_bank;

  bank_mapper_decode u_decode (
    .addr_top (cpu_addr[15:13]),
    .cpu_we   (cpu_we),
    .rgn_wr   (rgn_wr)
  );

  bank_mapper_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rgn_wr   (rgn_wr),
    .wdata    (cpu_wdata),
    .ram_en   (ram_en),
    .mode     (mode),
    .bank_lo  (bank_lo),
    .bank_hi  (bank_hi),
    .ram_bank (ram_bank)
  );

  bank_mapper_xlate #(.ROM_BANKS(ROM_BANKS)) u_xlate (
    .cpu_addr (cpu_addr),
    .bank_lo  (bank_lo),
    .bank_hi  (bank_hi),
    .ram_bank (ram_bank),
    .ram_en   (ram_en),
    .rom_addr (rom_addr),
    .ram_addr (ram_addr),
    .ram_cs   (ram_cs)
  );

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
  import bank_mapper_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  localparam int ROM_BW = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [15:0]                 cpu_addr,
  input logic [7:0]                  cpu_wdata,
  input logic                        cpu_we,
  input logic [ROM_BW+ROM_OFS_W-1:0] rom_addr,
  input logic                        ram_cs,
  input logic                        ram_en,
  input logic                        mode,
  input logic [BANK_LO_W-1:0]        bank_lo,
  input logic [BANK_HI_W-1:0]        bank_hi,
  input logic [BANK_HI_W-1:0]        ram_bank
);

  assert_gate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'b000 && cpu_wdata != RAM_ON_KEY && cpu_wdata != RAM_OFF_KEY)
      |=> $stable(ram_en));

  assert_bank_lo_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_lo != '0);

  assert_ram_bank_mode0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> ram_bank == '0);

  assert_mode1_clears_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'b011 && cpu_wdata[0]) |=> (bank_hi == '0 && mode));

  assert_mode0_ram0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15:13] == 3'b011 && !cpu_wdata[0]) |=> (ram_bank == '0 && !mode));

  assert_fixed_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> rom_addr[ROM_BW+ROM_OFS_W-1:ROM_OFS_W] == '0);

  assert_ramcs_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> (cpu_addr[15:13] == RAM_WINDOW && ram_en));

  assert_upper_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[15])
      |=> ($stable(ram_en) && $stable(mode) && $stable(bank_lo) && $stable(bank_hi) && $stable(ram_bank)));

endmodule

bind bank_mapper bank_mapper_chk #(.ROM_BANKS(ROM_BANKS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_we    (cpu_we),
  .rom_addr  (rom_addr),
  .ram_cs    (ram_cs),
  .ram_en    (ram_en),
  .mode      (mode),
  .bank_lo   (bank_lo),
  .bank_hi   (bank_hi),
  .ram_bank  (ram_bank)
);

// File: tb/bank_mapper_tb_top.sv
module bank_mapper_tb_top;

  localparam int ROM_BANKS = 64;
  localparam int ROM_BW    = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       cpu_addr = '0;
  logic [7:0]        cpu_wdata = '0;
  logic              cpu_we = 1'b0;
  logic [ROM_BW+13:0] rom_addr;
  logic [14:0]       ram_addr;
  logic              ram_cs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bank_mapper #(.ROM_BANKS(ROM_BANKS)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .rom_addr  (rom_addr),
    .ram_addr  (ram_addr),
    .ram_cs    (ram_cs)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  // one write cycle, ends at a falling edge with the strobe low
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic rom_bank_at(input logic [15:0] a, output int bank, output int ofs);
    cpu_addr = a; #1;
    bank = int'(rom_addr[ROM_BW+13:14]);
    ofs  = int'(rom_addr[13:0]);
  endtask

  task automatic sel_bank(output int bank);
    int ofs;
    rom_bank_at(16'h4000, bank, ofs);
  endtask

  task automatic ram_at(input logic [15:0] a, output int cs, output int rb);
    cpu_addr = a; #1;
    cs = int'(ram_cs);
    rb = int'(ram_addr[14:13]);
  endtask

  task automatic t_reset();
    int b, cs, rb;
    sel_bank(b);            check("R1 rom bank", b, 1);
    ram_at(16'hA000, cs, rb);
    check("R1 ram off", cs, 0);
    check("R1 ram bank", rb, 0);
  endtask

  task automatic t_ram_gate();
    int cs, rb;
    wr(16'h0000, 8'h0A);
    ram_at(16'hA000, cs, rb); check("R2 enable", cs, 1);
    wr(16'h1FFF, 8'h55);
    ram_at(16'hA000, cs, rb); check("R2 other value keeps on", cs, 1);
    wr(16'h0100, 8'h00);
    ram_at(16'hBFFF, cs, rb); check("R2 disable", cs, 0);
    wr(16'h0100, 8'hFF);
    ram_at(16'hBFFF, cs, rb); check("R2 other value keeps off", cs, 0);
    wr(16'h0000, 8'h0A);
    ram_at(16'h9FFF, cs, rb); check("R8 below window", cs, 0);
    ram_at(16'hC000, cs, rb); check("R8 above window", cs, 0);
    ram_at(16'hBFFF, cs, rb); check("R8 top of window", cs, 1);
  endtask

  task automatic t_bank_lo();
    int b;
    wr(16'h2000, 8'h00); sel_bank(b); check("R3 zero becomes one", b, 1);
    wr(16'h3FFF, 8'h1F); sel_bank(b); check("R3 max low", b, 31);
    wr(16'h2000, 8'hE3); sel_bank(b); check("R3 upper data ignored", b, 3);
  endtask

  task automatic t_bank_hi();
    int b, cs, rb;
    wr(16'h4000, 8'hFD); sel_bank(b); check("R4 mode0 high bits", b, 35);
    ram_at(16'hA000, cs, rb); check("R4 mode0 ram bank stays 0", rb, 0);
    wr(16'h2000, 8'h00); sel_bank(b); check("R3 high bits kept", b, 33);
    wr(16'h5FFF, 8'h03); sel_bank(b); check("R6 bit6 wraps", b, 33);
  endtask

  task automatic t_mode_switch();
    int b, cs, rb;
    wr(16'h6000, 8'h01); sel_bank(b); check("R5 mode1 clears high", b, 1);
    wr(16'h4000, 8'h02);
    sel_bank(b);                check("R4 mode1 rom untouched", b, 1);
    cpu_addr = 16'hA123; #1;
    check("R8 ram addr", int'(ram_addr), 32'h4123);
    check("R4 mode1 ram bank", int'(ram_addr[14:13]), 2);
    wr(16'h7FFF, 8'hFE);
    ram_at(16'hA000, cs, rb); check("R5 mode0 ram bank 0", rb, 0);
    wr(16'h4000, 8'h01); sel_bank(b); check("R4 back in mode0", b, 33);
    ram_at(16'hA000, cs, rb); check("R4 ram bank still 0", rb, 0);
  endtask

  task automatic t_windows();
    int b, o;
    rom_bank_at(16'h1234, b, o);
    check("R7 low window bank", b, 0); check("R7 low offset", o, 16'h1234);
    rom_bank_at(16'h7ABC, b, o);
    check("R7 high window bank", b, 33); check("R7 high offset", o, 16'h3ABC);
  endtask

  task automatic t_ignored();
    int b, cs, rb;
    wr(16'hA000, 8'h00);
    wr(16'hE000, 8'h00);
    wr(16'hC000, 8'h01);
    wr(16'hA000, 8'h05);
    ram_at(16'hA000, cs, rb); check("R9 ram still on", cs, 1);
    check("R9 ram bank kept", rb, 0);
    sel_bank(b); check("R9 rom bank kept", b, 33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram_gate();
    t_bank_lo();
    t_bank_hi();
    t_mode_switch();
    t_windows();
    t_ignored();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule